// File: doc/BRIEF.md
# Dibit-to-Word Rate-Matching Buffer

This block carries data from a fast serial clock domain into a slower read domain. The writer runs at half the serial bit rate and stores one 2-bit group per write clock when its enable is high. The reader runs on its own unrelated clock and takes one 16-bit word per read.

Eight consecutive 2-bit writes fill one word row of a dual-port store. Each write lands in the next slot of the row. Occupancy is not found by comparing pointers across domains. One bit of the write pointer changes level each time a row is completed. That single bit is synchronized into the read clock domain, and each change of level, rising or falling, gives a one-cycle increment pulse. The pulse drives an up/down word counter in the read domain, and accepted reads decrement it. The empty flag, the full flag and the count output are all derived from that counter.

Top module: `rate_match_buf`

## Requirements
- R1: While reset is applied, the outputs are `rd_empty`=1, `rd_full`=0, `rd_count`=0 and `rd_data`=0.
- R2: Eight accepted writes form one 16-bit word, least significant slot first. The k-th write of a word (k = 0..7) occupies bits [2k+1:2k].
- R3: `rd_count` rises by exactly one for each completed word, after a synchronization delay of a few read clocks. A partially written word (fewer than eight writes) is not counted.
- R4: A read with `rd_en`=1 and `rd_empty`=0 on a read-clock edge has two effects on that edge. `rd_data` presents the oldest stored word, and `rd_count` falls by one. Words leave in the order they were written.
- R5: A read while `rd_empty`=1 is ignored. The count stays 0 and the read position does not advance, so the next stored word is still returned intact.
- R6: When an increment pulse and an accepted read fall on the same read-clock edge, `rd_count` is unchanged.
- R7: `rd_full` is 1 exactly when `rd_count` equals the depth in words (8 by default). `rd_empty` is 1 exactly when `rd_count` is 0.
- R8: Both pointers wrap around the store. Over many more words than the depth, data still leaves in write order.
- R9: `rd_count` never exceeds the depth and never changes by more than one per read clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock (half bit rate) |
| wrst_n | input | 1 | Write-domain reset, active low |
| wr_en | input | 1 | Store `wr_data` on this write-clock edge |
| wr_data | input | 2 | Two-bit group to store |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain reset, active low |
| rd_en | input | 1 | Request one 16-bit word |
| rd_data | output | 16 | Last word read, registered |
| rd_empty | output | 1 | No complete word is buffered |
| rd_full | output | 1 | All rows hold complete words |
| rd_count | output | 4 | Number of complete words buffered |

## Verification
Suppose the synchronized pointer bit lost an edge or produced an extra pulse. `rd_count` would then disagree with the number of words written, and the bench sees this once the synchronizer has settled, a few read clocks later. A read pointer that advances on an ignored empty read shows up at the next read: the data returned is from the wrong row or is stale. The coincident increment-and-read case is swept over several phases, so a wrong priority rule leaves the count off by one after the window.

// File: rtl/rmb_pkg.sv
package rmb_pkg;
  // Direction of a word-count update in one read cycle
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Increment and decrement together cancel
  function automatic step_e step_kind(input logic inc, input logic dec);
    if (inc && !dec) return STEP_UP;
    if (dec && !inc) return STEP_DOWN;
    return STEP_HOLD;
  endfunction

  // Bit offset of a write slot inside its word row
  function automatic int unsigned slot_offset(input int unsigned slot, input int unsigned slot_w);
    return slot * slot_w;
  endfunction
endpackage

// File: rtl/rmb_wr_ctrl.sv
module rmb_wr_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WR_W  = 2,
  parameter int unsigned RD_W  = 16,
  localparam int unsigned RATIO  = RD_W / WR_W,
  localparam int unsigned LANE_W = $clog2(RATIO),
  localparam int unsigned ROW_W  = $clog2(DEPTH),
  localparam int unsigned WPTR_W = LANE_W + ROW_W
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  output logic [LANE_W-1:0] wr_lane,
  output logic [ROW_W-1:0]  wr_row,
  output logic              wr_word_bit
);
  logic [WPTR_W-1:0] wptr_q;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) wptr_q <= '0;
    else if (wr_en) wptr_q <= wptr_q + 1'b1;
  end

  assign wr_lane     = wptr_q[LANE_W-1:0];
  assign wr_row      = wptr_q[WPTR_W-1:LANE_W];
  // Lowest row bit changes level once per completed word
  assign wr_word_bit = wptr_q[LANE_W];
endmodule

// File: rtl/rmb_store.sv
module rmb_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WR_W  = 2,
  parameter int unsigned RD_W  = 16,
  localparam int unsigned RATIO  = RD_W / WR_W,
  localparam int unsigned LANE_W = $clog2(RATIO),
  localparam int unsigned ROW_W  = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [LANE_W-1:0] wlane,
  input  logic [ROW_W-1:0]  wrow,
  input  logic [WR_W-1:0]   wdata,
  input  logic [ROW_W-1:0]  rrow,
  output logic [RD_W-1:0]   rword
);
  import rmb_pkg::*;

  logic [RD_W-1:0] rows [DEPTH];

  for (genvar l = 0; l < RATIO; l++) begin : g_lane
    localparam int unsigned OFS = slot_offset(l, WR_W);
    always_ff @(posedge wclk) begin
      if (we && (wlane == LANE_W'(l))) rows[wrow][OFS +: WR_W] <= wdata;
    end
  end

  assign rword = rows[rrow];
endmodule

// File: rtl/rmb_edge_sync.sv
module rmb_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_lvl,
  output logic change_pulse
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_lvl};
  end

  // Either direction of a level change gives one pulse
  assign change_pulse = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/rmb_rd_ctrl.sv
module rmb_rd_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned RD_W  = 16,
  localparam int unsigned ROW_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rd_en,
  input  logic             word_inc,
  input  logic [RD_W-1:0]  row_word,
  output logic [ROW_W-1:0] rd_row,
  output logic             rd_pop,
  output logic [RD_W-1:0]  rd_data,
  output logic [CNT_W-1:0] rd_count,
  output logic             rd_empty,
  output logic             rd_full
);
  import rmb_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] rptr_q;
  step_e            step;

  assign rd_empty = (cnt_q == '0);
  assign rd_full  = (cnt_q == CNT_W'(DEPTH));
  assign rd_pop   = rd_en && !rd_empty;
  assign step     = step_kind(word_inc, rd_pop);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      cnt_q   <= '0;
      rptr_q  <= '0;
      rd_data <= '0;
    end else begin
      unique case (step)
        STEP_UP:   cnt_q <= cnt_q + 1'b1;
        STEP_DOWN: cnt_q <= cnt_q - 1'b1;
        default:   cnt_q <= cnt_q;
      endcase
      if (rd_pop) begin
        rptr_q  <= rptr_q + 1'b1;
        rd_data <= row_word;
      end
    end
  end

  assign rd_row   = rptr_q;
  assign rd_count = cnt_q;
endmodule

// File: rtl/rate_match_buf.sv
module rate_match_buf #(
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned WR_W        = 2,
  parameter int unsigned RD_W        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned RATIO  = RD_W / WR_W,
  localparam int unsigned LANE_W = $clog2(RATIO),
  localparam int unsigned ROW_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_en,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rd_en,
  output logic [RD_W-1:0]  rd_data,
  output logic             rd_empty,
  output logic             rd_full,
  output logic [CNT_W-1:0] rd_count
);
  logic [LANE_W-1:0] wr_lane;
  logic [ROW_W-1:0]  wr_row;
  logic              wr_word_bit;
  logic              word_inc;
  logic              rd_pop;
  logic [ROW_W-1:0]  rd_row;
  logic [RD_W-1:0]   row_word;

  rmb_wr_ctrl #(.DEPTH(DEPTH), .WR_W(WR_W), .RD_W(RD_W)) wr_ctrl_i (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en),
    .wr_lane(wr_lane), .wr_row(wr_row), .wr_word_bit(wr_word_bit)
  );

  rmb_store #(.DEPTH(DEPTH), .WR_W(WR_W), .RD_W(RD_W)) store_i (
    .wclk(wclk), .we(wr_en), .wlane(wr_lane), .wrow(wr_row), .wdata(wr_data),
    .rrow(rd_row), .rword(row_word)
  );

  rmb_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(rclk), .rst_n(rrst_n), .async_lvl(wr_word_bit), .change_pulse(word_inc)
  );

  rmb_rd_ctrl #(.DEPTH(DEPTH), .RD_W(RD_W)) rd_ctrl_i (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .word_inc(word_inc),
    .row_word(row_word), .rd_row(rd_row), .rd_pop(rd_pop), .rd_data(rd_data),
    .rd_count(rd_count), .rd_empty(rd_empty), .rd_full(rd_full)
  );
endmodule

// File: rtl/rmb_checker.sv
module rmb_checker #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned ROW_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             rclk,
  input logic             rrst_n,
  input logic             rd_en,
  input logic             word_inc,
  input logic             rd_pop,
  input logic [ROW_W-1:0] rd_row,
  input logic [CNT_W-1:0] rd_count,
  input logic             rd_empty,
  input logic             rd_full
);
  AST_NO_OVERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_count <= CNT_W'(DEPTH)); // R9

  AST_COUNT_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_count == $past(rd_count)) || (rd_count == $past(rd_count) + 1'b1)
    || (rd_count == $past(rd_count) - 1'b1)); // R9

  AST_CANCEL_HOLDS: assert property (@(posedge rclk) disable iff (!rrst_n)
    (word_inc && rd_pop) |=> $stable(rd_count)); // R6

  AST_EMPTY_READ_IGNORED: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && rd_empty && !word_inc) |=> ($stable(rd_count) && $stable(rd_row))); // R5

  AST_POP_ADVANCES: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_pop |=> (rd_row == $past(rd_row) + 1'b1)); // R4

  AST_FULL_NOT_EMPTY: assert property (@(posedge rclk) disable iff (!rrst_n)
    !(rd_full && rd_empty)); // R7
endmodule

bind rate_match_buf rmb_checker #(.DEPTH(DEPTH)) chk_i (
  .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .word_inc(word_inc),
  .rd_pop(rd_pop), .rd_row(rd_row), .rd_count(rd_count),
  .rd_empty(rd_empty), .rd_full(rd_full)
);

// File: tb/rate_match_buf_tb_top.sv
module rate_match_buf_tb_top;
  localparam int DEPTH = 8;
  localparam int SLOTS = 8; // 16-bit word / 2-bit write

  logic        wclk = 1'b0, rclk = 1'b0;
  logic        wrst_n = 1'b0, rrst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_data = '0;
  logic [15:0] rd_data;
  logic        rd_empty, rd_full;
  logic [3:0]  rd_count;

  int errors = 0, checks = 0;
  logic [15:0] expq[$];

  always #2 wclk = ~wclk; // 250 MHz
  always #5 rclk = ~rclk;

  rate_match_buf dut_i (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_full(rd_full), .rd_count(rd_count)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic put_dibit(input logic [1:0] d);
    @(negedge wclk); wr_en = 1'b1; wr_data = d;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic put_word(input logic [15:0] w);
    for (int k = 0; k < SLOTS; k++) begin
      @(negedge wclk); wr_en = 1'b1; wr_data = w[2*k +: 2];
    end
    @(negedge wclk); wr_en = 1'b0;
    expq.push_back(w);
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
  endtask

  task automatic pop_check(input string tag);
    logic [15:0] e;
    int c0;
    e = expq.pop_front();
    @(negedge rclk); c0 = rd_count; rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    check(rd_data == e, {tag, " data"}, rd_data, e);
  endtask

  task automatic t_reset();
    check(rd_empty == 1'b1, "R1 empty", rd_empty, 1);
    check(rd_full == 1'b0, "R1 full", rd_full, 0);
    check(rd_count == 0, "R1 count", rd_count, 0);
    check(rd_data == 0, "R1 data", rd_data, 0);
  endtask

  task automatic t_partial();
    logic [1:0] seq [8] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0};
    for (int k = 0; k < 7; k++) put_dibit(seq[k]);
    settle();
    check(rd_count == 0, "R3 partial not counted", rd_count, 0);
    check(rd_empty == 1'b1, "R3 partial empty", rd_empty, 1);
    put_dibit(seq[7]);
    settle();
    check(rd_count == 1, "R3 word counted", rd_count, 1);
    expq.push_back(16'h1BE4);
    pop_check("R2 slot order");
    check(rd_count == 0, "R4 count after read", rd_count, 0);
  endtask

  task automatic t_empty_read();
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    check(rd_count == 0, "R5 count after empty read", rd_count, 0);
    check(rd_empty == 1'b1, "R5 still empty", rd_empty, 1);
    put_word(16'hC3A5);
    settle();
    pop_check("R5 next word intact");
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      put_word(16'h1111 * (i + 1) ^ 16'h8000);
      settle();
      check(rd_count == i + 1, "R3 count per word", rd_count, i + 1);
    end
    check(rd_full == 1'b1, "R7 full at depth", rd_full, 1);
    pop_check("R4 first of full");
    check(rd_full == 1'b0, "R7 not full after read", rd_full, 0);
    check(rd_count == DEPTH - 1, "R4 decrement", rd_count, DEPTH - 1);
    while (expq.size() > 0) pop_check("R4 order");
    check(rd_empty == 1'b1, "R7 empty after drain", rd_empty, 1);
  endtask

  task automatic t_wrap();
    for (int r = 0; r < 3 * DEPTH; r++) begin
      put_word(16'(r * 16'h2F59 + 16'h0713));
      if (r % 3 == 2) begin
        settle();
        repeat (3) pop_check("R8 wrap order");
      end
    end
    check(rd_empty == 1'b1, "R8 empty after wrap", rd_empty, 1);
  endtask

  task automatic t_coincide();
    for (int d = 0; d < 6; d++) begin
      put_word(16'hA000 + 16'(d));
      settle();
      put_word(16'h5000 + 16'(d));
      repeat (d) @(negedge rclk);
      pop_check("R6 read near increment");
      settle();
      check(rd_count == 1, "R6 count after overlap", rd_count, 1);
      pop_check("R6 second word");
    end
  endtask

  initial begin
    repeat (4) @(negedge wclk);
    t_reset();
    wrst_n = 1'b1; rrst_n = 1'b1;
    repeat (2) @(negedge rclk);
    t_partial();
    t_empty_read();
    t_fill();
    t_wrap();
    t_coincide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wclk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule